// File: doc/BRIEF.md
# Destination MAC address filter

This block watches a byte-wide receive stream, pulls the 48-bit destination address out of the first six bytes of each frame and decides whether the frame may pass. The decision uses two inputs. The first is a small table of allowed addresses, each entry with its own valid bit. The second is a two-bit filtering mode that software sets.

The modes are nested. Mode 0 lets everything through. Mode 1 admits only table hits. Mode 2 also admits broadcast. Mode 3 also admits multicast.

The result comes out as a one-cycle strobe after the last byte of a frame. The strobe carries a pass flag and two flags that classify the address. Software fills the table through a 32-bit word port, two words per entry. An entry only changes when its low word is written and then its high word. The port is usable only while the receiver is disabled.

Top module: `mac_dst_filter`

## Requirements
- R1: The destination address is the first six bytes of a frame; the first byte received lands in address bits 47:40 and the sixth in bits 7:0.
- R2: With `mode_i` = 0 every frame passes, including frames shorter than six bytes.
- R3: With `mode_i` = 1 a frame passes only if its full address equals the address of an entry whose valid bit is set; entries with the valid bit clear never match.
- R4: With `mode_i` = 2 a frame passes if it passes under mode 1 or its address is all ones (broadcast).
- R5: With `mode_i` = 3 a frame passes if it passes under mode 2 or address bit 40 (bit 0 of the first byte) is set (multicast).
- R6: `bcast_o` flags an all-ones address and `mcast_o` flags address bit 40 set, so broadcast also raises `mcast_o`. A frame of fewer than six bytes raises neither flag and fails in modes 1 to 3.
- R7: `done_o` is high for exactly the one cycle after the clock edge that takes a byte with `rx_eof_i`. `pass_o`, `bcast_o` and `mcast_o` are zero whenever `done_o` is low.
- R8: Entry e sits at word address 2e and 2e+1. The even word holds address bits 31:0. The odd word holds address bits 47:32 in bits 15:0 and the valid bit in bit 16, and reads back zero in bits 31:17.
- R9: A high-word write commits an entry only when the previous accepted table write was a low-word write to the same entry. A low-word write alone changes nothing visible, and an unpaired high-word write is ignored.
- R10: While `rx_en_i` is high, table writes are dropped and table reads return zero. Read data appears on `tab_rdata_o` in the cycle after `tab_rd_i` and holds until the next read.
- R11: After reset every entry is zero and invalid, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enabled; locks the table port |
| mode_i | input | 2 | Filter mode 0..3 |
| rx_valid_i | input | 1 | Byte valid |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_data_i | input | 8 | Frame byte |
| tab_wr_i | input | 1 | Table word write |
| tab_rd_i | input | 1 | Table word read |
| tab_addr_i | input | AW | Table word address (2 words per entry) |
| tab_wdata_i | input | 32 | Write data |
| tab_rdata_o | output | 32 | Read data, registered |
| done_o | output | 1 | Per-frame result strobe |
| pass_o | output | 1 | Frame passes the filter |
| bcast_o | output | 1 | Broadcast destination |
| mcast_o | output | 1 | Multicast destination |

## Verification
The bench builds the filter with four entries, so the word address is three bits wide. Four entries are enough to hold a valid unicast entry, an invalid one, a valid multicast entry and one left empty. With these it drives the pairing rules of the write sequence against a neighbouring entry. Frames of one, three, six and longer lengths, including back-to-back frames, are replayed under every mode. These frames reach the short-frame case and the case where a new frame starts in the result cycle.

// File: rtl/mac_filt_pkg.sv
package mac_filt_pkg;
  localparam int MAC_W = 48;

  typedef enum logic [1:0] {
    MODE_ALL        = 2'd0,
    MODE_LIST       = 2'd1,
    MODE_LIST_BC    = 2'd2,
    MODE_LIST_BC_MC = 2'd3
  } filt_mode_e;

  typedef struct packed {
    logic             vld;
    logic [MAC_W-1:0] mac;
  } tab_ent_t;
endpackage

// File: rtl/mac_addr_cap.sv
module mac_addr_cap
  import mac_filt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [7:0]       data_i,
  output logic [MAC_W-1:0] mac_o,
  output logic             full_o,
  output logic             done_o
);
  localparam int NB = MAC_W / 8;
  localparam int CW = $clog2(NB + 1);

  logic [CW-1:0]    cnt_q;
  logic [MAC_W-1:0] mac_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mac_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= valid_i & eof_i;
      if (valid_i) begin
        if (sof_i) begin
          cnt_q <= CW'(1);
          mac_q <= {{(MAC_W-8){1'b0}}, data_i};
        end else if (cnt_q < CW'(NB)) begin
          cnt_q <= cnt_q + CW'(1);
          mac_q <= {mac_q[MAC_W-9:0], data_i};
        end
      end
    end
  end

  assign mac_o  = mac_q;
  assign full_o = (cnt_q == CW'(NB));
  assign done_o = done_q;

  a_r7_done_follows_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && eof_i |=> done_o);
  a_r7_done_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && eof_i));
  a_r1_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NB));
endmodule

// File: rtl/mac_tab.sv
module mac_tab
  import mac_filt_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int AW = $clog2(2 * ENTRIES),
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lock_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [MAC_W-1:0]   key_i,
  output logic [ENTRIES-1:0] hit_o
);
  tab_ent_t [ENTRIES-1:0] tab_q;
  logic                   pend_q;
  logic [IW-1:0]          pidx_q;
  logic [31:0]            plo_q;
  logic [31:0]            rdata_q;

  logic [IW-1:0] idx;
  logic          hi_sel, in_range, acc_wr;

  assign idx      = IW'(addr_i >> 1);
  assign hi_sel   = addr_i[0];
  assign in_range = (int'(idx) < ENTRIES);
  assign acc_wr   = wr_i & ~lock_i & in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tab_q   <= '0;
      pend_q  <= 1'b0;
      pidx_q  <= '0;
      plo_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (acc_wr) begin
        if (!hi_sel) begin
          pend_q <= 1'b1;
          pidx_q <= idx;
          plo_q  <= wdata_i;
        end else begin
          pend_q <= 1'b0;
          if (pend_q && pidx_q == idx) begin
            tab_q[idx].vld <= wdata_i[16];
            tab_q[idx].mac <= {wdata_i[15:0], plo_q};
          end
        end
      end
      if (rd_i) begin
        if (lock_i || !in_range) rdata_q <= '0;
        else if (hi_sel) rdata_q <= {15'd0, tab_q[idx].vld, tab_q[idx].mac[47:32]};
        else rdata_q <= tab_q[idx].mac[31:0];
      end
    end
  end

  assign rdata_o = rdata_q;

  // parallel compare, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = tab_q[g].vld && (tab_q[g].mac == key_i);
  end

  a_r10_locked_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && wr_i |=> $stable(tab_q));
  a_r10_locked_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && rd_i |=> rdata_o == 32'd0);
  a_r9_low_word_invisible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !addr_i[0] |=> $stable(tab_q));
  a_r9_orphan_high_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i[0] && !pend_q |=> $stable(tab_q));
endmodule

// File: rtl/mac_decide.sv
module mac_decide
  import mac_filt_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  filt_mode_e         mode_i,
  input  logic               done_i,
  input  logic               full_i,
  input  logic [MAC_W-1:0]   mac_i,
  input  logic [ENTRIES-1:0] hit_i,
  output logic               pass_o,
  output logic               bcast_o,
  output logic               mcast_o
);
  logic bc, mc, hit, ok;

  assign bc  = full_i & (&mac_i);
  assign mc  = full_i & mac_i[40];
  assign hit = full_i & (|hit_i);

  always_comb begin
    unique case (mode_i)
      MODE_ALL:     ok = 1'b1;
      MODE_LIST:    ok = hit;
      MODE_LIST_BC: ok = hit | bc;
      default:      ok = hit | bc | mc;
    endcase
  end

  assign pass_o  = done_i & ok;
  assign bcast_o = done_i & bc;
  assign mcast_o = done_i & mc;
endmodule

// File: rtl/mac_dst_filter.sv
module mac_dst_filter
  import mac_filt_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int AW = $clog2(2 * ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic [1:0]    mode_i,
  input  logic          rx_valid_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic [7:0]    rx_data_i,
  input  logic          tab_wr_i,
  input  logic          tab_rd_i,
  input  logic [AW-1:0] tab_addr_i,
  input  logic [31:0]   tab_wdata_i,
  output logic [31:0]   tab_rdata_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          bcast_o,
  output logic          mcast_o
);
  logic [MAC_W-1:0]   mac;
  logic               full;
  logic [ENTRIES-1:0] hit;

  mac_addr_cap u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rx_valid_i),
    .sof_i   (rx_sof_i),
    .eof_i   (rx_eof_i),
    .data_i  (rx_data_i),
    .mac_o   (mac),
    .full_o  (full),
    .done_o  (done_o)
  );

  mac_tab #(.ENTRIES(ENTRIES)) u_tab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (rx_en_i),
    .wr_i    (tab_wr_i),
    .rd_i    (tab_rd_i),
    .addr_i  (tab_addr_i),
    .wdata_i (tab_wdata_i),
    .rdata_o (tab_rdata_o),
    .key_i   (mac),
    .hit_o   (hit)
  );

  mac_decide #(.ENTRIES(ENTRIES)) u_dec (
    .mode_i  (filt_mode_e'(mode_i)),
    .done_i  (done_o),
    .full_i  (full),
    .mac_i   (mac),
    .hit_i   (hit),
    .pass_o  (pass_o),
    .bcast_o (bcast_o),
    .mcast_o (mcast_o)
  );

  a_r7_flags_need_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || bcast_o || mcast_o) |-> done_o);
  a_r6_bcast_is_mcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |-> mcast_o);
  a_r6_short_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !full |-> !bcast_o && !mcast_o);
  a_r2_open_mode_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_i == 2'd0 |-> pass_o);
endmodule

// File: tb/mac_dst_filter_test.sv
module mac_dst_filter_test;
  localparam int ENT = 4;
  localparam int AW  = 3;

  logic clk = 0, rst_n = 0;
  logic en = 0;
  logic [1:0] mode = 0;
  logic valid = 0, sof = 0, eof = 0;
  logic [7:0] data = 0;
  logic wr = 0, rd = 0;
  logic [AW-1:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic done, pass, bc, mc;

  always #10 clk = ~clk;

  mac_dst_filter #(.ENTRIES(ENT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(en), .mode_i(mode),
    .rx_valid_i(valid), .rx_sof_i(sof), .rx_eof_i(eof), .rx_data_i(data),
    .tab_wr_i(wr), .tab_rd_i(rd), .tab_addr_i(addr), .tab_wdata_i(wdata),
    .tab_rdata_o(rdata), .done_o(done), .pass_o(pass), .bcast_o(bc), .mcast_o(mc)
  );

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R11";

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [47:0] t_mac [ENT];
  bit          t_vld [ENT];
  bit          m_pend;
  int          m_pidx, m_cnt, ix;
  logic [31:0] m_plo, m_rd;
  logic [47:0] m_mac;
  bit          m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) begin t_mac[i] = 0; t_vld[i] = 0; end
      m_pend = 0; m_pidx = 0; m_plo = 0; m_rd = 0; m_cnt = 0; m_mac = 0; m_done = 0;
    end else begin
      ix = int'(addr) / 2;
      if (rd) begin
        if (en) m_rd = 0;
        else if (addr[0]) m_rd = {15'd0, t_vld[ix], t_mac[ix][47:32]};
        else m_rd = t_mac[ix][31:0];
      end
      if (wr && !en) begin
        if (!addr[0]) begin m_pend = 1; m_pidx = ix; m_plo = wdata; end
        else begin
          if (m_pend && m_pidx == ix) begin t_mac[ix] = {wdata[15:0], m_plo}; t_vld[ix] = wdata[16]; end
          m_pend = 0;
        end
      end
      m_done = valid && eof;
      if (valid) begin
        if (sof) begin m_cnt = 1; m_mac = {40'd0, data}; end
        else if (m_cnt < 6) begin m_cnt++; m_mac = {m_mac[39:0], data}; end
      end
    end
  end

  function automatic bit exp_pass(input int md);
    bit full, hit, b, m;
    full = (m_cnt == 6);
    hit = 0;
    for (int i = 0; i < ENT; i++) if (t_vld[i] && t_mac[i] == m_mac) hit = 1;
    hit = hit && full;
    b = full && (m_mac == 48'hFFFF_FFFF_FFFF);
    m = full && m_mac[40];
    case (md)
      0: return 1;
      1: return hit;
      2: return hit || b;
      default: return hit || b || m;
    endcase
  endfunction

  function automatic string mode_tag(input int md);
    case (md)
      0: return "R2";
      1: return "R1 R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit ep, eb, em;
      ep = m_done && exp_pass(int'(mode));
      eb = m_done && (m_cnt == 6) && (m_mac == 48'hFFFF_FFFF_FFFF);
      em = m_done && (m_cnt == 6) && m_mac[40];
      chk(done == m_done, "R7 done", done, m_done);
      chk(pass == ep, mode_tag(int'(mode)), pass, ep);
      chk(bc == eb, "R6 bcast", bc, eb);
      chk(mc == em, "R6 mcast", mc, em);
      chk(rdata == m_rd, tag, rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic twr(input int a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic trd(input int a);
    @(negedge clk); rd = 1; addr = AW'(a);
    @(negedge clk); rd = 0;
  endtask

  task automatic send(input logic [47:0] dst, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      valid = 1; sof = (i == 0); eof = (i == len - 1);
      data = (i < 6) ? dst[47 - 8*i -: 8] : 8'(i * 7);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); valid = 0; sof = 0; eof = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({done, pass, bc, mc} == 4'b0 && rdata == 0, "R11 reset outputs", {done, pass, bc, mc, rdata}, 0);
    for (int a = 0; a < 2 * ENT; a++) trd(a);

    tag = "R8";
    twr(0, 32'h2233_4455); twr(1, 32'h0001_0211);   // entry0 02:11:22:33:44:55 valid
    twr(2, 32'hCCDD_EE01); twr(3, 32'h0000_0ABB);   // entry1 0A:BB:CC:DD:EE:01 invalid
    for (int a = 0; a < 4; a++) trd(a);

    tag = "R9";
    twr(5, 32'h0001_FFFF); trd(5); trd(4);          // orphan high
    twr(6, 32'h1234_5678); trd(6);                  // low alone
    twr(4, 32'hAAAA_5555); twr(7, 32'h0001_0001); trd(7); trd(6);
    twr(5, 32'h0001_1111); trd(5); trd(4);          // pending already consumed
    twr(6, 32'h5E00_00FB); twr(7, 32'h0001_0100);   // entry3 01:00:5E:00:00:FB valid
    trd(6); trd(7);

    tag = "R10";
    en = 1;
    twr(0, 32'hFFFF_FFFF); twr(1, 32'h0001_FFFF);
    trd(0); trd(1);
    en = 0;
    trd(0); trd(1);
    en = 1;

    for (int md = 0; md < 4; md++) begin
      mode = 2'(md);
      send(48'h0211_2233_4455, 10); idle(2);
      send(48'h0ABB_CCDD_EE01, 8);  idle(2);
      send(48'hFFFF_FFFF_FFFF, 7);  idle(2);
      send(48'h0100_5E11_2233, 9);  idle(2);
      send(48'h0100_5E00_00FB, 6);  idle(2);
      send(48'h00AA_BBCC_DDEE, 12); idle(2);
      send(48'hFFFF_FF00_0000, 3);  idle(2);
      send(48'h0211_2233_4455, 1);  idle(2);
      send(48'h0211_2233_4455, 6);
      send(48'hFFFF_FFFF_FFFF, 6);
      send(48'h0311_2233_4455, 7);  idle(3);
    end

    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule